// File: doc/BRIEF.md
# Atomic Lock Word Unit

This unit owns a small bank of lock words that sit in a reserved address window at the very top of the address space. It is placed beside the memory pipeline stage, where it watches one or more requester ports. When a load falls in the window, the unit performs an atomic test-and-set. It returns the value the word held before the access and leaves a one in the word. To do this it stalls the memory stage for one extra cycle. A store into the window writes its data into the word, so storing zero frees a lock.

With two requesters, the unit keeps each read-modify-write atomic. Only one test-and-set is granted per cycle, and port 0 has fixed priority. A store aimed at a word whose test-and-set is still in progress is held until that operation completes. When the returned old value is nonzero, the lock was already taken. In that case the unit raises a per-port thread-switch hint, which a multithreaded core treats like a cache miss. Accesses outside the window get no response from this unit and leave its state alone.

Top module: `tas_sync_unit`

## Requirements
- R1: An access is claimed only when address bits [31:4] are all ones. Bits [3:0] then select one of the 16 lock words, so 0xFFFFFFF0 selects word 0 and 0xFFFFFFFF selects word 15. Any other address causes no stall, returns zero read data and changes no lock word.
- R2: After reset, all 16 lock words hold zero, every stall output is low, and all read data is zero.
- R3: A load into the window is a test-and-set. Stall is high in the cycle the load is granted and low in the following completion cycle. In the completion cycle, read data carries the word's previous value, and from then on the word holds one.
- R4: A store into the window writes its data into the selected word with no stall when nothing conflicts. Storing zero releases the lock, so the next test-and-set returns zero.
- R5: When several ports present test-and-set loads in the same cycle, the lowest-numbered port is granted and the others stay stalled. A port that loses on the same word is granted in the next cycle and reads one.
- R6: A store from another port to a word whose test-and-set is in its grant cycle or its completion cycle stays stalled until after the completion cycle, and its data then lands in the word.
- R7: Two stores to the same word in the same cycle let the lower-numbered port write first, and the other is stalled one cycle and writes next. Stores to different words proceed together without stall.
- R8: The thread-switch hint of a port is high exactly in its completion cycle when the returned old value is nonzero, and low otherwise.
- R9: Read data is zero in every cycle other than a test-and-set completion cycle, including the stalled grant cycle. A requester holds its request stable while its stall is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request present, per port |
| reqWrite | input | NUM_PORTS | 1 = store, 0 = load, per port |
| reqAddr | input | NUM_PORTS x ADDR_W | Byte address, per port |
| reqWdata | input | NUM_PORTS x DATA_W | Store data, per port |
| rspRdata | output | NUM_PORTS x DATA_W | Old lock value in completion cycle, else zero |
| reqStall | output | NUM_PORTS | Hold the memory stage this cycle |
| threadSwitch | output | NUM_PORTS | Lock was already held, switch thread |

## Verification
The bench runs two ports into the same word in the same cycle. A design that lacked arbitration, or that granted both ports, would return zero to both ports, so two requesters would each believe they own the lock. It also places a store beside a test-and-set on the same word. If that store slipped in during the grant or completion cycle, the store data would be lost or overwritten by the one, and the later readback would show the wrong value. Window-edge addresses (words 0 and 15) and an address just below the window catch a decoder that is off by a bit. The hint is checked both when the old value is zero and when it is nonzero.

// File: rtl/tas_pkg.sv
package tas_pkg;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic tasGo;   // perform read-modify-write this cycle
    logic stGo;    // commit store data this cycle
  } tsStrobe_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DONE = 1'b1
  } tsPhase_t;

endpackage

// File: rtl/tas_ctrl.sv
module tas_ctrl
  import tas_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 32,
  parameter int LOC_BITS  = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_PORTS-1:0]               reqValid,
  input  logic [NUM_PORTS-1:0]               reqWrite,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   reqAddr,
  output tsStrobe_t [NUM_PORTS-1:0]          strobe,
  output logic [NUM_PORTS-1:0]               doneVec,
  output logic [NUM_PORTS-1:0]               stall
);

  localparam int TAG_W = ADDR_W - LOC_BITS;

  logic [NUM_PORTS-1:0]                hit;
  logic [NUM_PORTS-1:0]                tasReq;
  logic [NUM_PORTS-1:0]                stReq;
  logic [NUM_PORTS-1:0]                tasGo;
  logic [NUM_PORTS-1:0]                stGo;
  logic [NUM_PORTS-1:0]                stBlock;
  logic [NUM_PORTS-1:0][LOC_BITS-1:0]  loc;
  logic [NUM_PORTS-1:0][LOC_BITS-1:0]  doneLoc;
  logic                                tasAny;
  logic [LOC_BITS-1:0]                 tasLoc;
  tsPhase_t                            phase [NUM_PORTS];

  // window decode per port
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      loc[p]    = reqAddr[p][LOC_BITS-1:0];
      hit[p]    = reqValid[p] && (reqAddr[p][ADDR_W-1:LOC_BITS] == {TAG_W{1'b1}});
      tasReq[p] = hit[p] && !reqWrite[p] && (phase[p] == PH_IDLE);
      stReq[p]  = hit[p] && reqWrite[p];
    end
  end

  // fixed-priority grant, one read-modify-write per cycle
  always_comb begin
    tasGo  = '0;
    tasAny = 1'b0;
    tasLoc = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (tasReq[p] && !tasAny) begin
        tasGo[p] = 1'b1;
        tasAny   = 1'b1;
        tasLoc   = loc[p];
      end
    end
  end

  // store hold-off against in-flight test-and-set and lower-port stores
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      stBlock[p] = tasAny && (tasLoc == loc[p]);
      for (int q = 0; q < NUM_PORTS; q++) begin
        if (q != p && phase[q] == PH_DONE && doneLoc[q] == loc[p])
          stBlock[p] = 1'b1;
        if (q < p && stReq[q] && loc[q] == loc[p])
          stBlock[p] = 1'b1;
      end
      stGo[p] = stReq[p] && !stBlock[p];
    end
  end

  assign stall = tasReq | (stReq & ~stGo);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign strobe[p].tasGo = tasGo[p];
    assign strobe[p].stGo  = stGo[p];
    assign doneVec[p]      = (phase[p] == PH_DONE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phase[p]   <= PH_IDLE;
        doneLoc[p] <= '0;
      end else if (phase[p] == PH_DONE) begin
        phase[p] <= PH_IDLE;
      end else if (tasGo[p]) begin
        phase[p]   <= PH_DONE;
        doneLoc[p] <= loc[p];
      end
    end

    // R3
    grant_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
      tasGo[p] |=> !stall[p]);
  end

  // R5
  one_tas_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tasGo));

endmodule

// File: rtl/tas_datapath.sv
module tas_datapath
  import tas_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int DATA_W        = 32,
  parameter int LOC_BITS      = 4,
  parameter bit THREAD_SWITCH = 1'b1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  tsStrobe_t [NUM_PORTS-1:0]          strobe,
  input  logic [NUM_PORTS-1:0]               doneVec,
  input  logic [NUM_PORTS-1:0][LOC_BITS-1:0] locIdx,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdata,
  output logic [NUM_PORTS-1:0]               switchHint
);

  localparam int NUM_LOCKS = 1 << LOC_BITS;

  logic [DATA_W-1:0]                 lockMem [NUM_LOCKS];
  logic [NUM_PORTS-1:0][DATA_W-1:0]  oldVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOCKS; i++) lockMem[i] <= '0;
      oldVal <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe[p].stGo) lockMem[locIdx[p]] <= wdata[p];
        if (strobe[p].tasGo) begin
          oldVal[p]           <= lockMem[locIdx[p]];
          lockMem[locIdx[p]]  <= DATA_W'(1);
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
    assign rdata[p] = doneVec[p] ? oldVal[p] : '0;

    if (THREAD_SWITCH) begin : g_hint
      assign switchHint[p] = doneVec[p] && (oldVal[p] != '0);
    end else begin : g_nohint
      assign switchHint[p] = 1'b0;
    end

    // R3
    tas_sets_one_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[p].tasGo |=> lockMem[$past(locIdx[p])] == DATA_W'(1));

    // R6
    tas_held_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[p].tasGo |=> ##1 lockMem[$past(locIdx[p], 2)] == DATA_W'(1));

    // R4
    store_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe[p].stGo |=> lockMem[$past(locIdx[p])] == $past(wdata[p]));
  end

endmodule

// File: rtl/tas_sync_unit.sv
module tas_sync_unit
  import tas_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int LOC_BITS      = 4,
  parameter bit THREAD_SWITCH = 1'b1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0]              reqValid,
  input  logic [NUM_PORTS-1:0]              reqWrite,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqWdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rspRdata,
  output logic [NUM_PORTS-1:0]              reqStall,
  output logic [NUM_PORTS-1:0]              threadSwitch
);

  tsStrobe_t [NUM_PORTS-1:0]          strobe;
  logic [NUM_PORTS-1:0]               doneVec;
  logic [NUM_PORTS-1:0][LOC_BITS-1:0] locIdx;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_loc
    assign locIdx[p] = reqAddr[p][LOC_BITS-1:0];
  end

  tas_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .LOC_BITS  (LOC_BITS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobe   (strobe),
    .doneVec  (doneVec),
    .stall    (reqStall)
  );

  tas_datapath #(
    .NUM_PORTS     (NUM_PORTS),
    .DATA_W        (DATA_W),
    .LOC_BITS      (LOC_BITS),
    .THREAD_SWITCH (THREAD_SWITCH)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .doneVec    (doneVec),
    .locIdx     (locIdx),
    .wdata      (reqWdata),
    .rdata      (rspRdata),
    .switchHint (threadSwitch)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_top_chk
    // R8
    hint_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      threadSwitch[p] |-> rspRdata[p] != '0);

    // R9
    rdata_not_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
      rspRdata[p] != '0 |-> !reqStall[p]);
  end

endmodule

// File: tb/test_tas_sync_unit.sv
module test_tas_sync_unit;

  localparam int NP = 2;
  localparam int AW = 32;
  localparam int DW = 32;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [NP-1:0]          reqValid;
  logic [NP-1:0]          reqWrite;
  logic [NP-1:0][AW-1:0]  reqAddr;
  logic [NP-1:0][DW-1:0]  reqWdata;
  logic [NP-1:0][DW-1:0]  rspRdata;
  logic [NP-1:0]          reqStall;
  logic [NP-1:0]          threadSwitch;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] expQ0 [$];
  logic [DW-1:0] expQ1 [$];

  always #4 clk = ~clk;

  tas_sync_unit i_tas_sync_unit (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .rspRdata     (rspRdata),
    .reqStall     (reqStall),
    .threadSwitch (threadSwitch)
  );

  function automatic logic [AW-1:0] winAddr(input logic [3:0] loc);
    return {28'hFFFFFFF, loc};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setReq(input int p, input logic v, input logic w,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    reqValid[p] = v;
    reqWrite[p] = w;
    reqAddr[p]  = a;
    reqWdata[p] = d;
  endtask

  // monitor: scoreboard compare at each test-and-set completion
  always begin
    @(negedge clk);
    #3;
    if (rstN === 1'b1) begin
      for (int p = 0; p < NP; p++) begin
        if (reqValid[p] && !reqWrite[p] && reqAddr[p][31:4] == 28'hFFFFFFF && !reqStall[p]) begin
          logic [DW-1:0] e;
          if ((p == 0 ? expQ0.size() : expQ1.size()) == 0) begin
            chk("R3 unexpected completion", 32'd1, 32'd0);
          end else begin
            e = (p == 0) ? expQ0.pop_front() : expQ1.pop_front();
            chk("R3 old value", rspRdata[p], e);
            chk("R8 switch hint", {31'd0, threadSwitch[p]}, {31'd0, e != 0});
          end
        end
      end
    end
  end

  // driver: one test-and-set, expected old value pushed to scoreboard
  task automatic tasOp(input int p, input logic [3:0] loc, input logic [DW-1:0] expOld);
    if (p == 0) expQ0.push_back(expOld); else expQ1.push_back(expOld);
    setReq(p, 1'b1, 1'b0, winAddr(loc), '0);
    #2;
    chk("R3 stall in grant cycle", {31'd0, reqStall[p]}, 32'd1);
    chk("R9 rdata zero while stalled", rspRdata[p], '0);
    @(negedge clk);
    #2;
    chk("R3 stall low in completion", {31'd0, reqStall[p]}, 32'd0);
    @(negedge clk);
    reqValid[p] = 1'b0;
  endtask

  task automatic storeOp(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    setReq(p, 1'b1, 1'b1, a, d);
    #2;
    chk("R4 store no stall", {31'd0, reqStall[p]}, 32'd0);
    @(negedge clk);
    reqValid[p] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    reqValid = '0; reqWrite = '0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R2 reset state
    chk("R2 stall reset", {30'd0, reqStall}, 32'd0);
    chk("R2 rdata reset p0", rspRdata[0], '0);
    chk("R2 hint reset", {30'd0, threadSwitch}, 32'd0);
    @(negedge clk);

    // R2 / R3 first test-and-set reads zero, second reads one
    tasOp(0, 4'd5, 32'd0);
    tasOp(0, 4'd5, 32'd1);
    // R4 release with zero from other port
    storeOp(1, winAddr(4'd5), 32'd0);
    tasOp(0, 4'd5, 32'd0);
    storeOp(0, winAddr(4'd7), 32'hA5);
    tasOp(1, 4'd7, 32'hA5);

    // R1 outside the window
    setReq(0, 1'b1, 1'b0, 32'hFFFFFFE7, '0);
    #2;
    chk("R1 no stall outside window", {31'd0, reqStall[0]}, 32'd0);
    chk("R1 no rdata outside window", rspRdata[0], '0);
    @(negedge clk);
    reqValid[0] = 1'b0;
    setReq(1, 1'b1, 1'b1, 32'h0000_0003, 32'h55);
    #2;
    chk("R1 no stall store outside", {31'd0, reqStall[1]}, 32'd0);
    @(negedge clk);
    reqValid[1] = 1'b0;
    setReq(1, 1'b1, 1'b1, 32'hFFFFFFE3, 32'h66);
    @(negedge clk);
    reqValid[1] = 1'b0;
    tasOp(0, 4'd3, 32'd0);          // R1 word 3 unchanged
    // R1 window edges
    storeOp(0, 32'hFFFFFFF0, 32'd9);
    storeOp(1, 32'hFFFFFFFF, 32'hC);
    tasOp(0, 4'd0, 32'd9);
    tasOp(1, 4'd15, 32'hC);

    // R5 simultaneous test-and-set on word 2
    expQ0.push_back(32'd0);
    expQ1.push_back(32'd1);
    setReq(0, 1'b1, 1'b0, winAddr(4'd2), '0);
    setReq(1, 1'b1, 1'b0, winAddr(4'd2), '0);
    #2;
    chk("R5 p0 stalled in grant", {31'd0, reqStall[0]}, 32'd1);
    chk("R5 p1 stalled losing", {31'd0, reqStall[1]}, 32'd1);
    @(negedge clk);
    #2;
    chk("R5 p0 completes", {31'd0, reqStall[0]}, 32'd0);
    chk("R5 p1 granted next", {31'd0, reqStall[1]}, 32'd1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    #2;
    chk("R5 p1 completes", {31'd0, reqStall[1]}, 32'd0);
    @(negedge clk);
    reqValid[1] = 1'b0;

    // R6 store against in-flight test-and-set on word 9
    expQ0.push_back(32'd0);
    setReq(0, 1'b1, 1'b0, winAddr(4'd9), '0);
    setReq(1, 1'b1, 1'b1, winAddr(4'd9), 32'h33);
    #2;
    chk("R6 store held in grant cycle", {31'd0, reqStall[1]}, 32'd1);
    @(negedge clk);
    #2;
    chk("R6 store held in completion", {31'd0, reqStall[1]}, 32'd1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    #2;
    chk("R6 store released", {31'd0, reqStall[1]}, 32'd0);
    @(negedge clk);
    reqValid[1] = 1'b0;
    tasOp(0, 4'd9, 32'h33);

    // R7 same-word stores
    setReq(0, 1'b1, 1'b1, winAddr(4'd11), 32'h10);
    setReq(1, 1'b1, 1'b1, winAddr(4'd11), 32'h20);
    #2;
    chk("R7 p0 store proceeds", {31'd0, reqStall[0]}, 32'd0);
    chk("R7 p1 store held", {31'd0, reqStall[1]}, 32'd1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    #2;
    chk("R7 p1 store proceeds", {31'd0, reqStall[1]}, 32'd0);
    @(negedge clk);
    reqValid[1] = 1'b0;
    tasOp(0, 4'd11, 32'h20);

    // R7 different-word stores together
    setReq(0, 1'b1, 1'b1, winAddr(4'd12), 32'd4);
    setReq(1, 1'b1, 1'b1, winAddr(4'd13), 32'd6);
    #2;
    chk("R7 distinct words no stall", {30'd0, reqStall}, 32'd0);
    @(negedge clk);
    reqValid = '0;
    tasOp(0, 4'd12, 32'd4);
    tasOp(1, 4'd13, 32'd6);

    repeat (2) @(negedge clk);
    chk("R3 scoreboard drained", 32'(expQ0.size() + expQ1.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule